// File: doc/BRIEF.md
# Three-Stage MASH Delta-Sigma Modulator

This block turns an unsigned 16-bit frequency selection fraction into a stream of signed 3-bit division offsets for a multi-modulus divider. Three first-order accumulator stages are cascaded. Each stage adds its input to its own 16-bit register, and its carry out is a 1-bit quantizer decision. Stage two accumulates the residue of stage one, and stage three accumulates the residue of stage two. The three carries are combined through digital differentiators, which gives the quantization error third-order high-pass shaping. The long-run mean of the offsets therefore tracks the fraction.

The modulator advances only when the divider asks for a new offset by pulsing the request input. It does not advance on every reference clock. A 16-bit maximal-length LFSR supplies one dither bit per update, and that bit is added at the LSB of the first accumulator to break up idle tones. The combined carry value lies between -3 and +4. One is subtracted from it, so the registered offset covers -4 to +3 in two's complement.

Top module: `mash3_dsm`

## Requirements
- R1: While rst_n is low and on the first cycle after it is released, offset_o reads 0. Reset clears all three accumulators, all carry delay registers, and loads the LFSR with 16'hACE1.
- R2: A cycle with req_i low changes nothing. offset_o, the accumulators, the delay registers and the LFSR all hold, so the sequence continues unaltered at the next request.
- R3: After a rising edge with req_i high, offset_o holds the new offset from that edge onward, in 3-bit two's complement (3'b100 = -4, 3'b011 = +3). It equals the raw combination minus one.
- R4: The raw combination is c1 + (c2 - c2') + (c3 - 2*c3' + c3''). Here ck is the carry of stage k on this update, a prime marks the value from the previous update, and a double prime marks the value from two updates back.
- R5: Each stage sums its 16-bit register and its 16-bit input modulo 2^16, and the carry out of bit 15 is the stage's quantizer output. Stage 1 adds frac_i. Stage 2 adds stage 1's new register value. Stage 3 adds stage 2's new register value.
- R6: The dither bit is bit 0 of the LFSR, added at the LSB of stage 1 on each update. The LFSR then shifts left, inserting at bit 0 the XOR of bits 15, 13, 12 and 10.
- R7: Over a run of K consecutive updates at a fixed fraction F, the sum of (offset + 1) is within 4 of (F*K + sum of dither bits) / 65536.
- R8: frac_i is sampled only at a rising edge with req_i high. A change of frac_i between requests has no effect until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe from the divider; one update per high cycle |
| frac_i | input | 16 | Unsigned frequency selection fraction |
| offset_o | output | 3 | Signed division offset, -4 to +3 |

## Verification
The assertions assume that frac_i and req_i are driven to known values once reset is released. They also assume that req_i may be high on any number of consecutive cycles, with no minimum gap. The bench drives every input away from the clock edge. It mixes back-to-back requests with idle gaps of several cycles, and it changes frac_i during some of those gaps, so that both the hold rule and the sampling rule are exercised. Fractions are swept across the extremes 0 and 65535, powers of two, and irregular values. Each offset is compared with an arithmetic model of the requirements.

// File: rtl/mash3_pkg.sv
package mash3_pkg;
    localparam int ACC_W   = 16;
    localparam int OUT_W   = 3;
    localparam int LFSR_W  = 16;
    localparam int SUM_W   = OUT_W + 2;

    typedef logic [ACC_W-1:0]  acc_t;
    typedef logic [OUT_W-1:0]  offset_t;
    typedef logic [SUM_W-1:0]  wide_t;

    // Zero-extend one carry bit into the combiner width.
    function automatic wide_t widen(input logic b);
        return {{(SUM_W-1){1'b0}}, b};
    endfunction
endpackage

// File: rtl/mash3_stage.sv
module mash3_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] addend,
    input  logic         cin,
    output logic [W-1:0] residue,
    output logic         carry
);
    logic [W-1:0] acc_q;
    logic [W:0]   sum;

    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, addend} + {{W{1'b0}}, cin};
        residue = sum[W-1:0];
        carry   = sum[W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= residue;
        end
    end
endmodule

// File: rtl/mash3_lfsr.sv
module mash3_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic dither
);
    logic [W-1:0] state_q;
    logic         feedback;

    always_comb begin
        feedback = ^(state_q & TAPS);
        dither   = state_q[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (en) begin
            state_q <= {state_q[W-2:0], feedback};
        end
    end
endmodule

// File: rtl/mash3_cancel.sv
module mash3_cancel
    import mash3_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en,
    input  logic    c1,
    input  logic    c2,
    input  logic    c3,
    output offset_t offset
);
    logic  c2_d_q, c3_d_q, c3_dd_q;
    wide_t raw;
    wide_t shifted;
    offset_t offset_q;

    always_comb begin
        raw = widen(c1)
            + widen(c2) - widen(c2_d_q)
            + widen(c3) - (widen(c3_d_q) << 1) + widen(c3_dd_q);
        shifted = raw - wide_t'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c2_d_q   <= 1'b0;
            c3_d_q   <= 1'b0;
            c3_dd_q  <= 1'b0;
            offset_q <= '0;
        end else if (en) begin
            c2_d_q   <= c2;
            c3_dd_q  <= c3_d_q;
            c3_d_q   <= c3;
            offset_q <= shifted[OUT_W-1:0];
        end
    end

    assign offset = offset_q;
endmodule

// File: rtl/mash3_dsm.sv
module mash3_dsm
    import mash3_pkg::*;
#(
    parameter int              FRAC_W    = ACC_W,
    parameter logic [LFSR_W-1:0] DITHER_SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [OUT_W-1:0]  offset_o
);
    localparam int NUM_STAGES = 3;

    logic [FRAC_W-1:0] stage_in  [NUM_STAGES];
    logic [FRAC_W-1:0] stage_res [NUM_STAGES];
    logic [NUM_STAGES-1:0] carry;
    logic [NUM_STAGES-1:0] stage_cin;
    logic dither;

    mash3_lfsr #(
        .W    (LFSR_W),
        .TAPS (16'hB400),
        .SEED (DITHER_SEED)
    ) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (req_i),
        .dither (dither)
    );

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        if (k == 0) begin : g_head
            assign stage_in[k]  = frac_i;
            assign stage_cin[k] = dither;
        end else begin : g_tail
            assign stage_in[k]  = stage_res[k-1];
            assign stage_cin[k] = 1'b0;
        end

        mash3_stage #(.W(FRAC_W)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (req_i),
            .addend  (stage_in[k]),
            .cin     (stage_cin[k]),
            .residue (stage_res[k]),
            .carry   (carry[k])
        );
    end

    mash3_cancel u_cancel (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (req_i),
        .c1     (carry[0]),
        .c2     (carry[1]),
        .c3     (carry[2]),
        .offset (offset_o)
    );
endmodule

// File: rtl/mash3_dsm_chk.sv
module mash3_dsm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req,
    input logic [2:0] offset,
    input logic       c1,
    input logic       c2_d,
    input logic       c3_d,
    input logic       c3_dd,
    input logic [15:0] lfsr
);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(offset));

    // R6
    lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != 16'h0000);

    // R4
    delay_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (c3_dd == $past(c3_d)));

    // R3
    max_needs_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !c1) |=> (offset != 3'b011));

    // R4
    min_needs_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !(c2_d && c3_d)) |=> (offset != 3'b100));
endmodule

bind mash3_dsm mash3_dsm_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req_i),
    .offset (offset_o),
    .c1     (carry[0]),
    .c2_d   (u_cancel.c2_d_q),
    .c3_d   (u_cancel.c3_d_q),
    .c3_dd  (u_cancel.c3_dd_q),
    .lfsr   (u_lfsr.state_q)
);

// File: tb/mash3_dsm_bench.sv
module mash3_dsm_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [15:0] frac_i = '0;
    logic [2:0]  offset_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model state
    int unsigned m_acc1, m_acc2, m_acc3;
    int unsigned m_lfsr;
    int m_c2d, m_c3d, m_c3dd;
    int m_exp;
    int dsum;

    always #2.5 clk = ~clk;

    mash3_dsm u_mash3_dsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .frac_i   (frac_i),
        .offset_o (offset_o)
    );

    function automatic int as_signed3(input logic [2:0] v);
        return v[2] ? int'(v) - 8 : int'(v);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_acc1 = 0; m_acc2 = 0; m_acc3 = 0;
        m_lfsr = 32'hACE1;
        m_c2d = 0; m_c3d = 0; m_c3dd = 0;
        m_exp = 0;
    endtask

    // R4 R5 R6: arithmetic model of one update
    task automatic model_step(input int unsigned f);
        int unsigned d, s;
        int c1, c2, c3, raw, fb;
        d = m_lfsr & 1;
        dsum += int'(d);
        s = m_acc1 + f + d;      c1 = int'(s >> 16); m_acc1 = s & 32'hFFFF;
        s = m_acc2 + m_acc1;     c2 = int'(s >> 16); m_acc2 = s & 32'hFFFF;
        s = m_acc3 + m_acc2;     c3 = int'(s >> 16); m_acc3 = s & 32'hFFFF;
        raw = c1 + c2 - m_c2d + c3 - 2 * m_c3d + m_c3dd;
        m_c2d = c2;
        m_c3dd = m_c3d;
        m_c3d = c3;
        fb = int'(((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1);
        m_lfsr = ((m_lfsr << 1) | fb) & 32'hFFFF;
        m_exp = raw - 1;
    endtask

    // one request cycle; result checked at the following negedge
    task automatic do_req(input logic [15:0] f, input string tag);
        frac_i = f;
        req_i  = 1'b1;
        model_step(f);
        @(negedge clk);
        req_i = 1'b0;
        check(tag, as_signed3(offset_o), m_exp);
    endtask

    initial begin
        model_reset();
        dsum = 0;
        @(negedge clk);
        check("R1 offset in reset", as_signed3(offset_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 offset after release", as_signed3(offset_o), 0);

        // R1 R3: first update after reset
        do_req(16'h4000, "R3 first offset");

        // R2 R8: idle gaps with frac_i changing; output must hold
        for (int g = 0; g < 20; g++) begin
            frac_i = 16'(g * 3331);
            for (int w = 0; w < 3; w++) begin
                @(negedge clk);
                check("R2 hold while idle", as_signed3(offset_o), m_exp);
            end
            do_req(16'h4000, "R8 sampled only on request");
        end

        // R4 R5 R6 R7: sweep fractions, back-to-back requests
        begin
            logic [15:0] fr [10];
            fr = '{16'h0000, 16'hFFFF, 16'h8000, 16'h0001, 16'h1234,
                   16'hC000, 16'h5555, 16'hAAAA, 16'h0100, 16'hFEFF};
            for (int i = 0; i < 10; i++) begin
                longint sum_out, lhs, rhs;
                int base_d;
                sum_out = 0;
                base_d = dsum;
                for (int k = 0; k < 3000; k++) begin
                    do_req(fr[i], "R4 R5 R6 offset sequence");
                    sum_out += longint'(as_signed3(offset_o) + 1);
                end
                lhs = sum_out * 65536;
                rhs = longint'(fr[i]) * 3000 + longint'(dsum - base_d);
                n_cmp++;
                if (lhs - rhs > 4 * 65536 || rhs - lhs > 4 * 65536) begin
                    n_bad++;
                    $display("FAIL R7 mean actual=%0d expected=%0d", sum_out, rhs / 65536);
                end
            end
        end

        // R2: sparse requests with alternating fractions
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            check("R2 hold between sparse requests", as_signed3(offset_o), m_exp);
            do_req(k[0] ? 16'h7FFF : 16'h9001, "R3 sparse offset");
        end

        // R1: reset mid-run clears state
        rst_n = 1'b0;
        #1;
        check("R1 async reset", as_signed3(offset_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        do_req(16'hFFFF, "R1 first offset after second reset");
        do_req(16'hFFFF, "R1 second offset after second reset");

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule